// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous 16-bit static RAM. It takes one word or byte request at a time and plays it out as a timed sequence of active-low strobes: chip select, output enable, write enable, and one enable per byte lane. The host offers a request with a valid/ready handshake: a read/write flag, a two-bit lane mask, a 19-bit address and the write word. Read results come back as a one-cycle valid pulse carrying the read word.

Every analog timing limit of the RAM becomes a whole number of clock cycles. The number is the limit in nanoseconds divided by the clock period, rounded up. A grade parameter picks the fast set of limits (55 ns cycle) or the slow set (70 ns cycle). The controller drives the data bus only while write enable is low. When the operation switches between read and write, an idle gap is inserted that is long enough for the RAM to release the bus.

Top module: `sramLaneCtrl`

## Requirements
- R1: After reset, chip select, output enable, write enable and both lane enables are high, the bus drive is off, `reqReady` is high and `rdValid` is low.
- R2: A read holds chip select and output enable low, with write enable high, for exactly ceil(access time / clock period) cycles: 7 at 8 ns, fast grade. Mask bit 0 enables the lower lane (bits 7:0) and mask bit 1 the upper lane (bits 15:8). A lane's active-low enable is low only if its mask bit is 1.
- R3: A read returns the bus word sampled at the end of the access window. Bytes of lanes whose mask bit is 0 are returned as zero. `rdValid` is high for exactly one cycle per read, and results come back in request order.
- R4: A write holds chip select and write enable low, with output enable high, for exactly ceil(max(pulse, select-to-end, address-to-end, data setup) / period) cycles: 6 at 8 ns, fast grade. The lane enables follow the mask. A write with mask 0 leaves the memory unchanged.
- R5: `memDrive` is high only while write enable is low, and `memDout` then carries the request's write word.
- R6: After a write strobe rises, chip select stays high for at least one cycle. Strobe cycles plus high cycles reach ceil(write cycle / period), which is 7.
- R7: When a write follows a read, at least ceil(release time / period) cycles (3) separate the rise of output enable from the start of the bus drive. When a read follows a write, the same count separates the rise of write enable from the fall of output enable.
- R8: `reqReady` drops on the cycle after a request is accepted and stays low until the operation has finished. A request held while `reqReady` is low is not taken.
- R9: `memAddr` stays constant while chip select is low, and it equals the accepted request's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMask | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write word |
| rdValid | output | 1 | One-cycle read result strobe |
| rdData | output | 16 | Read word, disabled lanes zero |
| memAddr | output | 19 | RAM address |
| memCsN | output | 1 | RAM chip select, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memLbN | output | 1 | Lower lane enable, active low |
| memUbN | output | 1 | Upper lane enable, active low |
| memDout | output | 16 | Data toward the RAM |
| memDin | input | 16 | Data from the RAM |
| memDrive | output | 1 | Drive enable for `memDout` |

## Verification
The cycle that returns a read result is also the first cycle in which `reqReady` is high again. So the `rdValid` pulse of one read and the acceptance of the next request fall together. The bench provokes this by issuing each new request as soon as ready is seen, and the scoreboard checks that the results still pop in order and with the right values. The bench also holds a write request during a read. It checks that ready stays low throughout and that a later readback shows the held write never reached memory.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_REC
  } ctlState_t;

  // active-high internal view of the memory-side strobes
  typedef struct packed {
    logic cs;
    logic oe;
    logic we;
    logic drive;
    logic latch;
  } memStrobe_t;

  function automatic int cyclesFor(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramLaneCtl.sv
module sramLaneCtl
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int WP_CYC  = 6,
  parameter int REC_CYC = 1,
  parameter int TA_CYC  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       accept,
  output memStrobe_t strb
);

  localparam int MAXC = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(REC_CYC, TA_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  ctlState_t     state;
  logic [CW-1:0] cnt;
  logic          opWrite;
  logic          lastWrite;
  logic          haveLast;

  function automatic logic [CW-1:0] opLoad(input logic wr);
    return wr ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
  endfunction

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      opWrite   <= 1'b0;
      lastWrite <= 1'b0;
      haveLast  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            opWrite <= reqWrite;
            if (haveLast && (reqWrite != lastWrite)) begin
              state <= ST_TURN;
              cnt   <= CW'(TA_CYC - 1);
            end else begin
              state <= reqWrite ? ST_WRITE : ST_READ;
              cnt   <= opLoad(reqWrite);
            end
          end
        end
        ST_TURN: begin
          if (cnt == '0) begin
            state <= opWrite ? ST_WRITE : ST_READ;
            cnt   <= opLoad(opWrite);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            state     <= ST_IDLE;
            lastWrite <= 1'b0;
            haveLast  <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_WRITE: begin
          if (cnt == '0) begin
            state <= ST_REC;
            cnt   <= CW'(REC_CYC - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_REC: begin
          if (cnt == '0) begin
            state     <= ST_IDLE;
            lastWrite <= 1'b1;
            haveLast  <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb       = '0;
    strb.cs    = (state == ST_READ) || (state == ST_WRITE);
    strb.oe    = (state == ST_READ);
    strb.we    = (state == ST_WRITE);
    strb.drive = (state == ST_WRITE);
    strb.latch = (state == ST_READ) && (cnt == '0);
  end

  // cycles since output enable was last active, saturating at the turnaround
  logic [CW-1:0] oeGap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       oeGap <= CW'(TA_CYC);
    else if (strb.oe)                oeGap <= '0;
    else if (oeGap < CW'(TA_CYC))    oeGap <= oeGap + CW'(1);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!strb.cs && !strb.drive)); // R1

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.oe && strb.we)); // R4

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.drive) |-> (oeGap >= CW'(TA_CYC))); // R7

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R8

endmodule

// File: rtl/sramLaneDp.sv
module sramLaneDp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  input  memStrobe_t        strb,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W/8-1:0] laneEnN,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDrive
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] capWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      maskQ <= '0;
      dataQ <= '0;
    end else if (accept) begin
      addrQ <= reqAddr;
      maskQ <= reqMask;
      dataQ <= reqWdata;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneEnN[l]         = ~(strb.cs & maskQ[l]);
    assign capWord[l*8 +: 8]  = maskQ[l] ? memDin[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.latch;
      if (strb.latch) rdData <= capWord;
    end
  end

  assign memAddr  = addrQ;
  assign memCsN   = ~strb.cs;
  assign memOeN   = ~strb.oe;
  assign memWeN   = ~strb.we;
  assign memDout  = dataQ;
  assign memDrive = strb.drive;

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R3

  AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (!rstN)
    memDrive |-> (!memWeN && !memCsN)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr)); // R9

endmodule

// File: rtl/sramLaneCtrl.sv
module sramLaneCtrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int FAST_GRADE    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqMask,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDrive
);

  // grade limits in ns
  localparam int T_ACCESS  = FAST_GRADE ? 55 : 70;
  localparam int T_RDCYC   = FAST_GRADE ? 55 : 70;
  localparam int T_WPULSE  = FAST_GRADE ? 40 : 50;
  localparam int T_SELEND  = FAST_GRADE ? 45 : 60;
  localparam int T_SETUP   = FAST_GRADE ? 25 : 30;
  localparam int T_WRCYC   = FAST_GRADE ? 55 : 70;
  localparam int T_RELEASE = FAST_GRADE ? 20 : 25;

  localparam int RD_CYC  = cyclesFor(maxOf(T_ACCESS, T_RDCYC), CLK_PERIOD_NS);
  localparam int WP_CYC  = cyclesFor(maxOf(maxOf(T_WPULSE, T_SELEND), T_SETUP), CLK_PERIOD_NS);
  localparam int WC_CYC  = cyclesFor(T_WRCYC, CLK_PERIOD_NS);
  localparam int REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
  localparam int TA_CYC  = maxOf(cyclesFor(T_RELEASE, CLK_PERIOD_NS), 1);
  localparam int LANES   = DATA_W / 8;

  memStrobe_t       strb;
  logic             accept;
  logic [LANES-1:0] laneEnN;

  sramLaneCtl #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .TA_CYC (TA_CYC)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .accept  (accept),
    .strb    (strb)
  );

  sramLaneDp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .accept  (accept),
    .reqAddr (reqAddr),
    .reqMask (reqMask),
    .reqWdata(reqWdata),
    .strb    (strb),
    .rdValid (rdValid),
    .rdData  (rdData),
    .memAddr (memAddr),
    .memCsN  (memCsN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .laneEnN (laneEnN),
    .memDout (memDout),
    .memDin  (memDin),
    .memDrive(memDrive)
  );

  assign memLbN = laneEnN[0];
  assign memUbN = laneEnN[LANES-1];

endmodule

// File: tb/sramLaneCtrl_test.sv
`timescale 1ns/1ps
module sramLaneCtrl_test;

  localparam int PER    = 8;
  localparam int RD_EXP = (55 + PER - 1) / PER;
  localparam int WP_EXP = (45 + PER - 1) / PER;
  localparam int WC_EXP = (55 + PER - 1) / PER;
  localparam int TA_EXP = (20 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqMask = 2'b00;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [18:0] memAddr;
  logic        memCsN, memOeN, memWeN, memLbN, memUbN, memDrive;
  logic [15:0] memDout;
  logic [15:0] memDin = 16'hEEEE;

  always #4 clk = ~clk;

  sramLaneCtrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqMask(reqMask), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memLbN(memLbN), .memUbN(memUbN),
    .memDout(memDout), .memDin(memDin), .memDrive(memDrive)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fillWord(input logic [18:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
  endfunction

  // RAM model
  logic [15:0] arr [int];
  bit          pend = 1'b0;
  logic [18:0] pA;
  logic [15:0] pD;
  logic [1:0]  pL;
  always @(negedge clk) begin
    logic [15:0] w;
    if (!memCsN && !memOeN && memWeN) begin
      w = arr.exists(int'(memAddr)) ? arr[int'(memAddr)] : fillWord(memAddr);
      memDin = {memUbN ? 8'hEE : w[15:8], memLbN ? 8'hEE : w[7:0]};
    end else begin
      memDin = 16'hEEEE;
    end
    if (!memCsN && !memWeN) begin
      pend = 1'b1; pA = memAddr; pD = memDout; pL = {memUbN, memLbN};
    end else if (pend) begin
      w = arr.exists(int'(pA)) ? arr[int'(pA)] : fillWord(pA);
      if (!pL[0]) w[7:0]  = pD[7:0];
      if (!pL[1]) w[15:8] = pD[15:8];
      if (pL != 2'b11) arr[int'(pA)] = w;
      pend = 1'b0;
    end
  end

  // shadow and scoreboard
  logic [15:0] shadow [int];
  logic [15:0] expQ [$];
  logic [1:0]  curMask = 2'b00;
  logic [15:0] curData = '0;
  logic [18:0] curAddr = '0;

  function automatic logic [15:0] expRead(input logic [18:0] a, input logic [1:0] m);
    logic [15:0] w;
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : fillWord(a);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic doOp(input bit wr, input logic [1:0] m, input logic [18:0] a,
                      input logic [15:0] d);
    logic [15:0] w;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqMask = m; reqAddr = a; reqWdata = d;
    curMask = m; curData = d; curAddr = a;
    if (wr) begin
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : fillWord(a);
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end else begin
      expQ.push_back(expRead(a, m));
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor
  int weRun = 0, oeRun = 0, csHigh = 100, lastWeRun = 0;
  int sinceOe = 100, sinceWe = 100;
  bit lastWr = 1'b0, prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rdValid) begin
        if (expQ.size() == 0) check(1'b0, "R3", "unexpected rdValid", rdData, 0);
        else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R3", "read word", rdData, e);
        end
      end
      if (prevValid) check(!rdValid, "R3", "rdValid longer than one cycle", rdValid, 0);
      prevValid = rdValid;

      if (memDrive && memWeN) check(1'b0, "R5", "drive outside write strobe", memDrive, 0);

      if (!memCsN) begin
        if (csHigh > 0 && lastWr) begin
          check(csHigh >= 1, "R6", "recovery high cycles", csHigh, 1);
          check(lastWeRun + csHigh >= WC_EXP, "R6", "write cycle length",
                lastWeRun + csHigh, WC_EXP);
        end
        csHigh = 0;
        check(memAddr == curAddr, "R9", "address during select", memAddr, curAddr);
      end else begin
        csHigh++;
      end

      if (!memWeN) begin
        weRun++;
        if (weRun == 1) check(sinceOe >= TA_EXP, "R7", "read-to-write gap", sinceOe, TA_EXP);
        check(memDrive && memOeN && !memCsN, "R5", "drive/oe/cs during write",
              {memDrive, memOeN, memCsN}, 3'b110);
        check({memUbN, memLbN} == ~curMask, "R4", "write lane enables",
              {memUbN, memLbN}, ~curMask);
        check(memDout == curData, "R5", "write data on bus", memDout, curData);
      end else if (weRun > 0) begin
        check(weRun == WP_EXP, "R4", "write strobe cycles", weRun, WP_EXP);
        lastWeRun = weRun; weRun = 0; sinceWe = 1; lastWr = 1'b1;
      end else begin
        sinceWe++;
      end

      if (!memOeN) begin
        oeRun++;
        if (oeRun == 1) check(sinceWe >= TA_EXP, "R7", "write-to-read gap", sinceWe, TA_EXP);
        check(memWeN && !memCsN, "R2", "we high and cs low during read",
              {memWeN, memCsN}, 2'b10);
        check({memUbN, memLbN} == ~curMask, "R2", "read lane enables",
              {memUbN, memLbN}, ~curMask);
      end else if (oeRun > 0) begin
        check(oeRun == RD_EXP, "R2", "read strobe cycles", oeRun, RD_EXP);
        oeRun = 0; sinceOe = 1; lastWr = 1'b0;
      end else begin
        sinceOe++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL R8 watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, during and after reset
    check({memCsN, memOeN, memWeN, memLbN, memUbN} == 5'h1F, "R1", "strobes in reset",
          {memCsN, memOeN, memWeN, memLbN, memUbN}, 5'h1F);
    rstN = 1'b1;
    @(negedge clk);
    check({memCsN, memOeN, memWeN, memLbN, memUbN} == 5'h1F, "R1", "strobes after reset",
          {memCsN, memOeN, memWeN, memLbN, memUbN}, 5'h1F);
    check(!memDrive && reqReady && !rdValid, "R1", "drive/ready/valid after reset",
          {memDrive, reqReady, rdValid}, 3'b010);

    doOp(1'b1, 2'b11, 19'h00010, 16'h1234);   // R4 word write
    doOp(1'b0, 2'b11, 19'h00010, 16'h0);      // R7 write then read, R3
    doOp(1'b0, 2'b01, 19'h00010, 16'h0);      // R2 lower lane only
    doOp(1'b0, 2'b10, 19'h00010, 16'h0);      // R2 upper lane only
    doOp(1'b1, 2'b10, 19'h00010, 16'hAB99);   // R7 read then write, upper byte
    doOp(1'b1, 2'b01, 19'h7FFFF, 16'h0055);   // R6 back-to-back writes
    doOp(1'b0, 2'b11, 19'h7FFFF, 16'h0);
    doOp(1'b0, 2'b11, 19'h40000, 16'h0);      // untouched word
    doOp(1'b1, 2'b00, 19'h00010, 16'hFFFF);   // R4 empty mask changes nothing
    doOp(1'b0, 2'b11, 19'h00010, 16'h0);
    doOp(1'b0, 2'b00, 19'h00010, 16'h0);      // R3 all lanes disabled returns zero

    // R8 request held while busy is not taken
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqMask = 2'b11; reqAddr = 19'h00020;
    curMask = 2'b11; curAddr = 19'h00020;
    expQ.push_back(expRead(19'h00020, 2'b11));
    @(posedge clk); @(negedge clk);
    reqWrite = 1'b1; reqWdata = 16'hDEAD;
    for (int i = 0; i < 3; i++) begin
      check(!reqReady, "R8", "ready low while busy", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    doOp(1'b0, 2'b11, 19'h00020, 16'h0);      // still the untouched pattern
    doOp(1'b0, 2'b11, 19'h00010, 16'h0);

    repeat (30) @(negedge clk);
    check(expQ.size() == 0, "R3", "all reads returned", expQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule